// File: doc/BRIEF.md
# Multi-Synthesizer Phase Sync Sequencer

This block brings two or more direct digital synthesizers into a known phase relationship, such as quadrature. The synthesizers share one reference clock. After a host request, the block drives a common reset pulse to all of them. It then loads each device in turn over a shared 8-bit data bus, using a separate write strobe per device. Each device receives the same frequency word and its own 5-bit phase code, where one code step is 11.25 degrees and code 8 is a 90-degree offset. Only after every device holds its full 40-bit word does the block raise a single update strobe. The update strobe goes through a final flip-flop on the reference clock, so every device sees it on the same edge and all outputs start together.

The host gives a frequency word, the packed phase codes and an update-pulse length, then pulses `req`. `busy` stays high for the whole operation. `done` pulses for one cycle after the update strobe has fallen. A request made while busy has no effect.

Top module: `phase_sync_seq`

## Requirements
- R1: While and after `rst_n` is asserted, and until a request is accepted, `dds_reset`, `dds_wclk`, `dds_update`, `busy` and `done` are all low.
- R2: A request accepted while idle first produces one `dds_reset` pulse, high for exactly RST_CYC clocks (default 5, never fewer than 5). No write strobe and no update strobe is high during that pulse.
- R3: Each device receives 5 bytes on `dds_data`. The first byte is `{phase_code[4:0], 3'b000}`. The next four are frequency bits [31:24], [23:16], [15:8] and [7:0], in that order. Devices are loaded in index order, and device d takes `phase_codes[5*d +: 5]`.
- R4: For each byte, the data is valid one clock before its write strobe rises. The strobe is high for exactly one clock, and the data is held for one clock after the strobe falls. At most one write strobe is high at any time.
- R5: `dds_update` rises only after every device has received all 5 write strobes since the last reset pulse. No write strobe is high while `dds_update` is high.
- R6: Each accepted request produces exactly one `dds_update` pulse, common to all devices. The pulse lasts `upd_len` clocks, except that a value of 0 or 1 gives 2 clocks.
- R7: `busy` is high from the clock after a request is accepted until the operation ends. `done` then pulses high for exactly one clock, with `busy` and `dds_update` low.
- R8: A request made while `busy` is high is ignored: it produces no second reset pulse, and the loaded bytes keep the values of the request that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a sync operation (taken when idle) |
| freq_word | input | 32 | Frequency tuning word for all devices |
| phase_codes | input | NUM_DEV*5 | Packed 5-bit phase code per device |
| upd_len | input | 8 | Update strobe length in clocks (minimum 2 applied) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| dds_reset | output | 1 | Common reset to all devices |
| dds_data | output | 8 | Shared data bus |
| dds_wclk | output | NUM_DEV | Per-device write strobe |
| dds_update | output | 1 | Common registered update strobe |

## Verification
The main sequence runs with an exhaustive sweep of device-0 phase codes 0 to 31. Device 1 is always offset by code 8, the quadrature case, so a swapped device order or a misplaced phase field shows up as a byte mismatch. Frequency words come from a multiplicative hash, so every byte lane carries distinct values and a byte-order error is exposed. The update length cycles through 0 to 5, which separates the clamp to 2 from a pass-through length. Every other run sends a second request with inverted data while busy; this separates an ignored request from one that restarts or corrupts the load.

// File: rtl/phase_sync_pkg.sv
package phase_sync_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_RESET  = 3'd1,
    SQ_LOAD   = 3'd2,
    SQ_UPDATE = 3'd3,
    SQ_DRAIN  = 3'd4
  } sq_state_e;

  localparam int BUS_W     = 8;
  localparam int UPD_MIN   = 2;
  localparam int RST_MIN   = 5;
  localparam int STEP_LAST = 2;
  localparam int DRAIN_LEN = 2;

endpackage

// File: rtl/phase_sync_bytesel.sv
module phase_sync_bytesel #(
  parameter int NUM_DEV = 2,
  parameter int PHASE_W = 5,
  parameter int FREQ_W  = 32,
  parameter int DEV_W   = 1,
  parameter int BI_W    = 3
) (
  input  logic [FREQ_W-1:0]          freq,
  input  logic [NUM_DEV*PHASE_W-1:0] phases,
  input  logic [DEV_W-1:0]           dev_idx,
  input  logic [BI_W-1:0]            byte_idx,
  output logic [7:0]                 byte_out
);
  localparam int FREQ_BYTES = FREQ_W / 8;
  localparam int NBYTES     = FREQ_BYTES + 1;

  logic [PHASE_W-1:0] ph_arr [NUM_DEV];
  logic [7:0]         lane   [NBYTES];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_ph
    assign ph_arr[g] = phases[g*PHASE_W +: PHASE_W];
  end

  assign lane[0] = {ph_arr[dev_idx], {(8-PHASE_W){1'b0}}};

  for (genvar k = 0; k < FREQ_BYTES; k++) begin : g_fb
    assign lane[k+1] = freq[FREQ_W-1-8*k -: 8];
  end

  assign byte_out = lane[byte_idx];

endmodule

// File: rtl/phase_sync_loader.sv
module phase_sync_loader
  import phase_sync_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int BYTES   = 5,
  parameter int DEV_W   = 1,
  parameter int BI_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active,
  output logic [DEV_W-1:0] dev_idx,
  output logic [BI_W-1:0]  byte_idx,
  output logic             strobe,
  output logic             finish
);
  logic             act_q, act_d;
  logic [DEV_W-1:0] dev_q, dev_d;
  logic [BI_W-1:0]  byt_q, byt_d;
  logic [1:0]       stp_q, stp_d;
  logic             last_byte, last_dev, last_step;

  assign last_byte = (byt_q == BI_W'(BYTES-1));
  assign last_dev  = (dev_q == DEV_W'(NUM_DEV-1));
  assign last_step = (stp_q == 2'(STEP_LAST));

  always_comb begin
    act_d = act_q;
    dev_d = dev_q;
    byt_d = byt_q;
    stp_d = stp_q;
    if (start) begin
      act_d = 1'b1;
      dev_d = '0;
      byt_d = '0;
      stp_d = '0;
    end else if (act_q) begin
      if (last_step) begin
        stp_d = '0;
        if (last_byte) begin
          byt_d = '0;
          if (last_dev) act_d = 1'b0;
          else          dev_d = dev_q + DEV_W'(1);
        end else begin
          byt_d = byt_q + BI_W'(1);
        end
      end else begin
        stp_d = stp_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      dev_q <= '0;
      byt_q <= '0;
      stp_q <= '0;
    end else begin
      act_q <= act_d;
      dev_q <= dev_d;
      byt_q <= byt_d;
      stp_q <= stp_d;
    end
  end

  assign active   = act_q;
  assign dev_idx  = dev_q;
  assign byte_idx = byt_q;
  assign strobe   = act_q && (stp_q == 2'd1);
  assign finish   = act_q && last_step && last_byte && last_dev;

endmodule

// File: rtl/phase_sync_upd_reg.sv
module phase_sync_upd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/phase_sync_seq.sv
module phase_sync_seq
  import phase_sync_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int PHASE_W = 5,
  parameter int FREQ_W  = 32,
  parameter int LEN_W   = 8,
  parameter int RST_CYC = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic [FREQ_W-1:0]          freq_word,
  input  logic [NUM_DEV*PHASE_W-1:0] phase_codes,
  input  logic [LEN_W-1:0]           upd_len,
  output logic                       busy,
  output logic                       done,
  output logic                       dds_reset,
  output logic [BUS_W-1:0]           dds_data,
  output logic [NUM_DEV-1:0]         dds_wclk,
  output logic                       dds_update
);
  localparam int BYTES_PER_DEV = FREQ_W / 8 + 1;
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int BI_W    = $clog2(BYTES_PER_DEV);
  localparam int RST_LEN = (RST_CYC < RST_MIN) ? RST_MIN : RST_CYC;
  localparam int LEN_MAX = (1 << LEN_W) - 1;
  localparam int CNT_MAX = (RST_LEN > LEN_MAX) ? RST_LEN : LEN_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  sq_state_e                  state_q, state_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d, cnt_inc;
  logic                       accept, ld_start, done_nx;
  logic [FREQ_W-1:0]          freq_q;
  logic [NUM_DEV*PHASE_W-1:0] phase_q;
  logic [LEN_W-1:0]           len_q;

  logic                       ld_active, ld_strobe, ld_finish;
  logic [DEV_W-1:0]           ld_dev;
  logic [BI_W-1:0]            ld_byte;
  logic [BUS_W-1:0]           sel_byte;
  logic [NUM_DEV-1:0]         wclk_nx;

  logic                       rst_q, upd_raw_q, done_q;
  logic [BUS_W-1:0]           data_q;
  logic [NUM_DEV-1:0]         wclk_q;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    accept   = 1'b0;
    ld_start = 1'b0;
    done_nx  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          state_d = SQ_RESET;
          cnt_d   = '0;
        end
      end
      SQ_RESET: begin
        if (cnt_inc == CNT_W'(RST_LEN)) begin
          state_d  = SQ_LOAD;
          ld_start = 1'b1;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      SQ_LOAD: begin
        if (ld_finish) begin
          state_d = SQ_UPDATE;
          cnt_d   = '0;
        end
      end
      SQ_UPDATE: begin
        if (cnt_inc == CNT_W'(len_q)) begin
          state_d = SQ_DRAIN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      SQ_DRAIN: begin
        if (cnt_inc == CNT_W'(DRAIN_LEN)) begin
          state_d = SQ_IDLE;
          done_nx = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: begin
        state_d = SQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      freq_q  <= '0;
      phase_q <= '0;
      len_q   <= LEN_W'(UPD_MIN);
    end else if (accept) begin
      freq_q  <= freq_word;
      phase_q <= phase_codes;
      len_q   <= (upd_len < LEN_W'(UPD_MIN)) ? LEN_W'(UPD_MIN) : upd_len;
    end
  end

  phase_sync_loader #(
    .NUM_DEV (NUM_DEV),
    .BYTES   (BYTES_PER_DEV),
    .DEV_W   (DEV_W),
    .BI_W    (BI_W)
  ) u_loader (
    .clk      (clk),
    .rst_n    (rs_n),
    .start    (ld_start),
    .active   (ld_active),
    .dev_idx  (ld_dev),
    .byte_idx (ld_byte),
    .strobe   (ld_strobe),
    .finish   (ld_finish)
  );

  phase_sync_bytesel #(
    .NUM_DEV (NUM_DEV),
    .PHASE_W (PHASE_W),
    .FREQ_W  (FREQ_W),
    .DEV_W   (DEV_W),
    .BI_W    (BI_W)
  ) u_bytesel (
    .freq     (freq_q),
    .phases   (phase_q),
    .dev_idx  (ld_dev),
    .byte_idx (ld_byte),
    .byte_out (sel_byte)
  );

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_wclk
    assign wclk_nx[g] = ld_strobe && (ld_dev == DEV_W'(g));
  end

  // output register stage: equal latency on every device pin
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      rst_q     <= 1'b0;
      wclk_q    <= '0;
      upd_raw_q <= 1'b0;
      done_q    <= 1'b0;
      data_q    <= '0;
    end else begin
      rst_q     <= (state_q == SQ_RESET);
      wclk_q    <= wclk_nx;
      upd_raw_q <= (state_q == SQ_UPDATE);
      done_q    <= done_nx;
      if (ld_active) data_q <= sel_byte;
    end
  end

  // final re-registration of the common update strobe
  phase_sync_upd_reg u_upd_reg (
    .clk   (clk),
    .rst_n (rs_n),
    .en    (1'b1),
    .d     (upd_raw_q),
    .q     (dds_update)
  );

  assign busy      = (state_q != SQ_IDLE);
  assign done      = done_q;
  assign dds_reset = rst_q;
  assign dds_data  = data_q;
  assign dds_wclk  = wclk_q;

endmodule

// File: rtl/phase_sync_checker.sv
module phase_sync_checker #(
  parameter int NUM_DEV = 2,
  parameter int BYTES   = 5,
  parameter int RST_MIN = 5,
  parameter int UPD_MIN = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               dds_reset,
  input logic [7:0]         dds_data,
  input logic [NUM_DEV-1:0] dds_wclk,
  input logic               dds_update
);
  logic [3:0]  wr_cnt [NUM_DEV];
  logic [15:0] rst_run, upd_run;
  logic        all_loaded;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         wr_cnt[g] <= '0;
      else if (dds_reset)                 wr_cnt[g] <= '0;
      else if (dds_wclk[g] && wr_cnt[g] != 4'hF) wr_cnt[g] <= wr_cnt[g] + 4'd1;
    end
  end

  always_comb begin
    all_loaded = 1'b1;
    for (int i = 0; i < NUM_DEV; i++)
      if (wr_cnt[i] != 4'(BYTES)) all_loaded = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_run <= '0;
      upd_run <= '0;
    end else begin
      rst_run <= dds_reset  ? rst_run + 16'd1 : '0;
      upd_run <= dds_update ? upd_run + 16'd1 : '0;
    end
  end

  AST_RESET_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dds_reset) |-> (rst_run >= 16'(RST_MIN)));  // R2
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    dds_reset |-> (dds_wclk == '0 && !dds_update));  // R2
  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dds_wclk));  // R4
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (|dds_wclk) |-> $stable(dds_data));  // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|dds_wclk) |-> $stable(dds_data));  // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dds_wclk) |=> (dds_wclk == '0));  // R4
  AST_LOADED_BEFORE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dds_update) |-> all_loaded);  // R5
  AST_NO_WRITE_IN_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    dds_update |-> (dds_wclk == '0));  // R5
  AST_UPDATE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dds_update) |-> (upd_run >= 16'(UPD_MIN)));  // R6
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!dds_update && !busy));  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7

endmodule

bind phase_sync_seq phase_sync_checker #(
  .NUM_DEV (NUM_DEV),
  .BYTES   (BYTES_PER_DEV)
) u_phase_sync_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .dds_reset  (dds_reset),
  .dds_data   (dds_data),
  .dds_wclk   (dds_wclk),
  .dds_update (dds_update)
);

// File: tb/phase_sync_seq_bench.sv
module phase_sync_seq_bench;
  localparam int NUM_DEV = 2;
  localparam int PHASE_W = 5;
  localparam int NB      = 5;
  localparam int RST_EXP = 5;

  logic                       clk = 1'b0;
  logic                       rst_n;
  logic                       req;
  logic [31:0]                freq_word;
  logic [NUM_DEV*PHASE_W-1:0] phase_codes;
  logic [7:0]                 upd_len;
  logic                       busy, done, dds_reset, dds_update;
  logic [7:0]                 dds_data;
  logic [NUM_DEV-1:0]         dds_wclk;

  always #10 clk = ~clk;

  phase_sync_seq u_phase_sync_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .freq_word(freq_word),
    .phase_codes(phase_codes), .upd_len(upd_len), .busy(busy), .done(done),
    .dds_reset(dds_reset), .dds_data(dds_data), .dds_wclk(dds_wclk),
    .dds_update(dds_update)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [7:0] cap [NUM_DEV][NB];
  int  ncap [NUM_DEV];
  int  rst_run, rst_w, rst_pulses, upd_run, upd_w, upd_pulses;
  int  seq_err, stab_err, early_upd;
  bit  prev_any, prev_upd, prev_rst;
  logic [7:0] prev_data;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stats();
    for (int d = 0; d < NUM_DEV; d++) ncap[d] = 0;
    rst_run = 0; rst_w = 0; rst_pulses = 0;
    upd_run = 0; upd_w = 0; upd_pulses = 0;
    seq_err = 0; stab_err = 0; early_upd = 0;
  endtask

  // one clock: wait for the falling edge and record the device pins
  task automatic tick();
    bit any;
    @(negedge clk);
    any = |dds_wclk;
    if (dds_reset) begin
      if (!prev_rst) rst_pulses++;
      rst_run++;
      if (any || dds_update) seq_err++;
    end else if (prev_rst) begin
      rst_w = rst_run;
      rst_run = 0;
    end
    if (any) begin
      if (prev_any) stab_err++;
      if (dds_data !== prev_data) stab_err++;
      for (int d = 0; d < NUM_DEV; d++) begin
        if (dds_wclk[d]) begin
          for (int e = 0; e < NUM_DEV; e++) begin
            if (e < d && ncap[e] != NB) seq_err++;
            if (e > d && ncap[e] != 0)  seq_err++;
          end
          if (ncap[d] < NB) cap[d][ncap[d]] = dds_data;
          ncap[d]++;
        end
      end
    end else if (prev_any && dds_data !== prev_data) begin
      stab_err++;
    end
    if (dds_update) begin
      if (!prev_upd) begin
        upd_pulses++;
        for (int d = 0; d < NUM_DEV; d++) if (ncap[d] != NB) early_upd++;
      end
      upd_run++;
      if (any) seq_err++;
    end else if (prev_upd) begin
      upd_w = upd_run;
      upd_run = 0;
    end
    prev_any  = any;
    prev_upd  = dds_update;
    prev_rst  = dds_reset;
    prev_data = dds_data;
  endtask

  task automatic run_op(input logic [31:0] fw, input logic [4:0] p0, input logic [4:0] p1,
                        input logic [7:0] len, input bit poke);
    int guard;
    int exp_w;
    logic [7:0] exp_b;
    logic [4:0] ph;
    clear_stats();
    freq_word   = fw;
    phase_codes = {p1, p0};
    upd_len     = len;
    req         = 1'b1;
    tick();
    req = 1'b0;
    tick();
    chk(busy === 1'b1, "R7 busy after accept", busy, 1);
    if (poke) begin
      freq_word   = ~fw;
      phase_codes = {p0, p1} ^ 10'h3FF;
      upd_len     = len + 8'd7;
      req         = 1'b1;
      tick();
      req = 1'b0;
    end
    guard = 0;
    while (done !== 1'b1 && guard < 3000) begin
      tick();
      guard++;
    end
    chk(done === 1'b1, "R7 done seen", done, 1);
    chk(busy === 1'b0 && dds_update === 1'b0, "R7 idle at done", {busy, dds_update}, 0);
    tick();
    chk(done === 1'b0, "R7 done single cycle", done, 0);
    for (int i = 0; i < 4; i++) tick();
    chk(rst_w == RST_EXP, "R2 reset width", rst_w, RST_EXP);
    chk(rst_pulses == 1, poke ? "R8 reset pulses with ignored request" : "R2 reset pulses",
        rst_pulses, 1);
    for (int d = 0; d < NUM_DEV; d++) begin
      chk(ncap[d] == NB, "R3 byte count", ncap[d], NB);
      ph = (d == 0) ? p0 : p1;
      for (int k = 0; k < NB; k++) begin
        exp_b = (k == 0) ? {ph, 3'b000} : 8'((fw >> (8 * (NB - 1 - k))) & 32'hFF);
        chk(cap[d][k] === exp_b, poke ? "R8 R3 loaded byte" : "R3 loaded byte",
            cap[d][k], exp_b);
      end
    end
    chk(stab_err == 0, "R4 data/strobe timing errors", stab_err, 0);
    chk(seq_err == 0, "R5 R2 ordering errors", seq_err, 0);
    chk(early_upd == 0, "R5 update before all loaded", early_upd, 0);
    exp_w = (len < 2) ? 2 : int'(len);
    chk(upd_pulses == 1, "R6 update pulse count", upd_pulses, 1);
    chk(upd_w == exp_w, "R6 update width", upd_w, exp_w);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL R7 watchdog expired actual=%0d expected<=150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; freq_word = '0; phase_codes = '0; upd_len = '0;
    prev_any = 1'b0; prev_upd = 1'b0; prev_rst = 1'b0; prev_data = '0;
    clear_stats();
    repeat (3) @(negedge clk);
    chk({busy, done, dds_reset, dds_update, dds_wclk} === '0, "R1 outputs in reset",
        {busy, done, dds_reset, dds_update, dds_wclk}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    chk({busy, done, dds_reset, dds_update, dds_wclk} === '0, "R1 outputs after reset",
        {busy, done, dds_reset, dds_update, dds_wclk}, 0);
    // quadrature sweep: device 1 sits 8 codes (90 degrees) after device 0
    for (int i = 0; i < 32; i++) begin
      run_op(32'h9E3779B9 * (i + 1), 5'(i), 5'((i + 8) % 32), 8'(i % 6), (i % 2) == 1);
    end
    run_op(32'hFFFF_FFFF, 5'd31, 5'd0, 8'd9, 1'b0);
    run_op(32'h0000_0000, 5'd0, 5'd31, 8'd1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule